// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM

This block is a synthesizable model of a small synchronous static memory with a registered, two-stage read path and a built-in four-word burst sequencer. A host opens an access with one of two address strobes. The processor strobe always starts a read. The controller strobe can start a read or a write on the same edge. Later edges with neither strobe asserted continue the burst. On each of these edges the burst position either steps to the next word or stays where it is.

Only the two lowest address bits take part in a burst. They step in either linear or interleaved order, and the upper bits stay fixed. Writes are masked per byte lane. The output is a data bus plus a drive flag, which stands in for a three-state pad. A sleep input freezes the command path, and a three-input chip select can end a burst with single-cycle deselect.

Top module: `burst_sync_sram`

## Requirements
- R1: While `rst_n` is low and after it is released, `dout_drive` is 0 and `dout` is all zeros until a read has been issued. A continuation edge with no burst open performs no access.
- R2: The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. A strobe edge with any of the three inactive is a deselect edge and starts no access.
- R3: A read registered on edge k shows its word on `dout` after edge k+1, with `dout_drive`=1 when `oe_n`=0.
- R4: `dout_drive` is 1 only when `oe_n` is 0 and read data is valid. When `dout_drive` is 0, `dout` reads as zero.
- R5: On an edge where `ctrl_strb_n` opens a cycle, the write controls and `din` are sampled on that same edge and written to `addr`.
- R6: On an edge where `proc_strb_n` opens a cycle, the write controls are ignored and a read of the base word starts. A write on the next continuation edge with `adv_n`=1 stores into the base word.
- R7: `wr_all_n`=0 writes all lanes. Otherwise `byte_wr_n`=0 writes every lane i whose `lane_wr_n[i]` is 0; lane i is `din[8i+7:8i]`. With both `wr_all_n` and `byte_wr_n` high, nothing is written.
- R8: A continuation edge with `adv_n`=0 accesses the next burst word. With n advances since the load and base low bits b, the low two bits are (b+n) mod 4 when `lin_order`=1 and b XOR n when `lin_order`=0. The upper bits never change, so the burst wraps within its group of four.
- R9: A continuation edge with `adv_n`=1 accesses the same word again and holds the burst count. A write datum is therefore taken twice.
- R10: After a deselect edge k, a read already in flight still appears after edge k. `dout_drive` is 0 from edge k+1 on.
- R11: While `sleep`=1 all commands are ignored: no write, and the open burst and read pipeline are cleared. `dout_drive` is 0 after that edge, and memory contents are kept.
- R12: When both strobes are low on the same edge, the processor strobe wins, so the write controls are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| proc_strb_n | input | 1 | Processor address strobe, active low |
| ctrl_strb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low; high suspends |
| wr_all_n | input | 1 | Global write of all lanes, active low |
| byte_wr_n | input | 1 | Byte write enable, active low |
| lane_wr_n | input | LANES | Per-lane write strobes, active low |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| lin_order | input | 1 | Burst order: 1 linear, 0 interleaved |
| sleep | input | 1 | Sleep; ignores commands while high |
| din | input | LANES*LANE_W | Write data |
| dout | output | LANES*LANE_W | Read data, zero when not driven |
| dout_drive | output | 1 | Output bus driven |

## Verification
The hardest state to reach from the ports is a burst that has wrapped past its fourth word after one or more suspended edges. Reaching it proves that the count holds on a suspend and that the low bits wrap without touching the upper bits. The stimulus table walks a linear burst from a mid-group base through a suspend and a full wrap. It then walks an interleaved burst from a different base. The read pipeline makes every word show up one row late, so each row checks the word fetched by the row before it. Write masking and the ignored writes on processor-strobe edges, under sleep and with both strobes low are all checked by reading the affected word back later in the table.

// File: rtl/bsram_pkg.sv
package bsram_pkg;

   // low address bits that take part in a burst (four words)
   localparam int BURST_BITS = 2;

   typedef enum logic [2:0] {
      CMD_CONT,    // no strobe: continue or idle
      CMD_LOAD_P,  // processor strobe, selected
      CMD_LOAD_C,  // controller strobe, selected
      CMD_DESEL,   // strobe while not selected
      CMD_SLEEP    // sleep input high
   } bsram_cmd_e;

endpackage

// File: rtl/bsram_cmd_dec.sv
module bsram_cmd_dec
   import bsram_pkg::*;
(
   input  logic       sleep,
   input  logic       proc_strb_n,
   input  logic       ctrl_strb_n,
   input  logic       sel_ok,
   output bsram_cmd_e cmd
);

   always_comb begin
      if (sleep)
         cmd = CMD_SLEEP;
      else if (!proc_strb_n)
         cmd = sel_ok ? CMD_LOAD_P : CMD_DESEL;
      else if (!ctrl_strb_n)
         cmd = sel_ok ? CMD_LOAD_C : CMD_DESEL;
      else
         cmd = CMD_CONT;
   end

endmodule

// File: rtl/bsram_burst_addr.sv
module bsram_burst_addr
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  bsram_cmd_e            cmd,
   input  logic                  adv_n,
   input  logic                  lin_order,
   input  logic [ADDR_W-1:0]     ld_addr,
   output logic [ADDR_W-1:0]     acc_addr,
   output logic                  active,
   output logic [BURST_BITS-1:0] cnt
);

   localparam int BB = BURST_BITS;

   logic [ADDR_W-1:0] base_q;
   logic [BB-1:0]     cnt_q, cnt_nxt;
   logic              act_q;

   function automatic logic [BB-1:0] seq_low(input logic [BB-1:0] b,
                                             input logic [BB-1:0] n,
                                             input logic          lin);
      return lin ? (b + n) : (b ^ n);
   endfunction

   always_comb begin
      cnt_nxt = cnt_q;
      if (cmd == CMD_CONT && act_q && !adv_n)
         cnt_nxt = cnt_q + BB'(1);
      if (cmd == CMD_LOAD_P || cmd == CMD_LOAD_C)
         acc_addr = ld_addr;
      else
         acc_addr = {base_q[ADDR_W-1:BB], seq_low(base_q[BB-1:0], cnt_nxt, lin_order)};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q <= '0;
         cnt_q  <= '0;
         act_q  <= 1'b0;
      end else begin
         case (cmd)
            CMD_LOAD_P, CMD_LOAD_C: begin
               base_q <= ld_addr;
               cnt_q  <= '0;
               act_q  <= 1'b1;
            end
            CMD_DESEL, CMD_SLEEP: act_q <= 1'b0;
            CMD_CONT:             cnt_q <= cnt_nxt;
            default: ;
         endcase
      end
   end

   assign active = act_q;
   assign cnt    = cnt_q;

endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [LANES-1:0]        wr_lane,
   input  logic [ADDR_W-1:0]       wr_addr,
   input  logic [LANES*LANE_W-1:0] wdata,
   input  logic                    rd_req,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic                    flush,
   output logic [LANES*LANE_W-1:0] rdata,
   output logic                    rvalid
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [ADDR_W-1:0] rd_addr_q;
   logic              pend_q, vld_q;

   // stage 1 captures the address, stage 2 the array word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_addr_q <= '0;
         pend_q    <= 1'b0;
         vld_q     <= 1'b0;
      end else if (flush) begin
         pend_q <= 1'b0;
         vld_q  <= 1'b0;
      end else begin
         pend_q <= rd_req;
         vld_q  <= pend_q;
         if (rd_req)
            rd_addr_q <= rd_addr;
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic [LANE_W-1:0] lane_mem [DEPTH];
      logic [LANE_W-1:0] lane_q;

      always_ff @(posedge clk) begin
         if (wr_lane[g])
            lane_mem[wr_addr] <= wdata[g*LANE_W +: LANE_W];
         lane_q <= lane_mem[rd_addr_q];
      end

      assign rdata[g*LANE_W +: LANE_W] = lane_q;
   end

   assign rvalid = vld_q;

endmodule

// File: rtl/burst_sync_sram.sv
module burst_sync_sram
   import bsram_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LANES  = 4,
   parameter int LANE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [ADDR_W-1:0]       addr,
   input  logic                    proc_strb_n,
   input  logic                    ctrl_strb_n,
   input  logic                    adv_n,
   input  logic                    wr_all_n,
   input  logic                    byte_wr_n,
   input  logic [LANES-1:0]        lane_wr_n,
   input  logic                    sel_a_n,
   input  logic                    sel_b,
   input  logic                    sel_c_n,
   input  logic                    oe_n,
   input  logic                    lin_order,
   input  logic                    sleep,
   input  logic [LANES*LANE_W-1:0] din,
   output logic [LANES*LANE_W-1:0] dout,
   output logic                    dout_drive
);

   localparam int DATA_W = LANES * LANE_W;

   if (ADDR_W <= BURST_BITS) begin : g_bad_addr_w
      $error("burst_sync_sram: ADDR_W must exceed the burst field width");
   end
   if (LANES < 1 || LANE_W < 1) begin : g_bad_lanes
      $error("burst_sync_sram: LANES and LANE_W must be positive");
   end

   bsram_cmd_e            cmd;
   logic                  sel_ok;
   logic [ADDR_W-1:0]     acc_addr;
   logic                  active;
   logic [BURST_BITS-1:0] cnt;
   logic [LANES-1:0]      mask, wr_lane;
   logic                  wr_ok, rd_req;
   logic [DATA_W-1:0]     rdata;
   logic                  rvalid;

   assign sel_ok = !sel_a_n && sel_b && !sel_c_n;

   bsram_cmd_dec u_dec (
      .sleep       (sleep),
      .proc_strb_n (proc_strb_n),
      .ctrl_strb_n (ctrl_strb_n),
      .sel_ok      (sel_ok),
      .cmd         (cmd)
   );

   bsram_burst_addr #(.ADDR_W(ADDR_W)) u_addr (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd       (cmd),
      .adv_n     (adv_n),
      .lin_order (lin_order),
      .ld_addr   (addr),
      .acc_addr  (acc_addr),
      .active    (active),
      .cnt       (cnt)
   );

   always_comb begin
      if (!wr_all_n)
         mask = '1;
      else if (!byte_wr_n)
         mask = ~lane_wr_n;
      else
         mask = '0;
   end

   // processor-strobe edges never write; their write controls count next edge
   assign wr_ok   = (cmd == CMD_LOAD_C) || (cmd == CMD_CONT && active);
   assign wr_lane = wr_ok ? mask : '0;
   assign rd_req  = (cmd == CMD_LOAD_P) || (wr_ok && mask == '0);

   bsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_lane (wr_lane),
      .wr_addr (acc_addr),
      .wdata   (din),
      .rd_req  (rd_req),
      .rd_addr (acc_addr),
      .flush   (cmd == CMD_SLEEP),
      .rdata   (rdata),
      .rvalid  (rvalid)
   );

   assign dout_drive = rvalid && !oe_n;
   assign dout       = dout_drive ? rdata : '0;

endmodule

// File: rtl/bsram_chk.sv
module bsram_chk
   import bsram_pkg::*;
(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sleep,
   input bsram_cmd_e            cmd,
   input logic                  active,
   input logic                  adv_n,
   input logic [BURST_BITS-1:0] cnt,
   input logic                  rd_req,
   input logic                  wr_any,
   input logic                  rvalid
);

   AST_SUSPEND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_CONT && active && adv_n) |=> $stable(cnt)); // R9

   AST_STEP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_CONT && active && !adv_n) |=> ((cnt - $past(cnt)) == BURST_BITS'(1))); // R8

   AST_READ_PIPE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_req ##1 !sleep) |=> rvalid); // R3

   AST_DESEL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_DESEL) |=> ##1 !rvalid); // R10

   AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      sleep |=> !rvalid); // R11

   AST_WRITE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_any |=> ##1 !rvalid); // R5

endmodule

bind burst_sync_sram bsram_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .sleep  (sleep),
   .cmd    (cmd),
   .active (active),
   .adv_n  (adv_n),
   .cnt    (cnt),
   .rd_req (rd_req),
   .wr_any (|wr_lane),
   .rvalid (rvalid)
);

// File: tb/test_burst_sync_sram.sv
`timescale 1ns/100ps
module test_burst_sync_sram;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  addr;
   logic        p_n, c_n, adv_n, g_n, bwe_n;
   logic [3:0]  bs_n;
   logic        sa_n, sb, sc_n, oe_n, lin, slp;
   logic [31:0] din, dout;
   logic        drv;
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done  = 1'b0;

   always #2.5 clk = ~clk;

   burst_sync_sram i_burst_sync_sram (
      .clk(clk), .rst_n(rst_n), .addr(addr), .proc_strb_n(p_n), .ctrl_strb_n(c_n),
      .adv_n(adv_n), .wr_all_n(g_n), .byte_wr_n(bwe_n), .lane_wr_n(bs_n),
      .sel_a_n(sa_n), .sel_b(sb), .sel_c_n(sc_n), .oe_n(oe_n), .lin_order(lin),
      .sleep(slp), .din(din), .dout(dout), .dout_drive(drv)
   );

   typedef struct packed {
      logic        p, c, v, g, b;
      logic [3:0]  bs;
      logic        s, o, l, z;
      logic [7:0]  a;
      logic [31:0] d;
      logic        ed;
      logic [31:0] eq;
   } vec_t;

   localparam int NV = 30;
   // p c v g b bs s o l z addr din exp_drive exp_dout
   localparam vec_t VT [NV] = '{
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h10,32'hA0A00010,1'b0,32'h0},        // 0  R5
      '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'hA0A00011,1'b0,32'h0},        // 1
      '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'hA0A00012,1'b0,32'h0},        // 2
      '{1'b1,1'b1,1'b0,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'hA0A00013,1'b0,32'h0},        // 3
      '{1'b0,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h12,32'hDEADBEEF,1'b0,32'h0},        // 4  R6
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00012},        // 5
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00013},        // 6  R8
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00010},        // 7  R9
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00010},        // 8
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b1,1'b1,1'b0,8'h00,32'h0,1'b0,32'h0},               // 9  R4
      '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b0,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00012},        // 10 R10
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b0,32'h0},               // 11
      '{1'b0,1'b1,1'b1,1'b1,1'b0,4'h0,1'b1,1'b1,1'b1,1'b0,8'h21,32'h12345678,1'b0,32'h0},        // 12 R7
      '{1'b1,1'b1,1'b1,1'b0,1'b1,4'hF,1'b1,1'b1,1'b1,1'b0,8'h00,32'hC1C10021,1'b0,32'h0},        // 13
      '{1'b1,1'b1,1'b1,1'b1,1'b0,4'hA,1'b1,1'b0,1'b1,1'b0,8'h00,32'h55555555,1'b0,32'h0},        // 14
      '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h21,32'h0,1'b0,32'h0},               // 15 R3
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hC1550055},        // 16
      '{1'b0,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h11,32'h0,1'b1,32'hC1550055},        // 17 R8
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h00,32'h0,1'b1,32'hA0A00011},        // 18
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h00,32'h0,1'b1,32'hA0A00010},        // 19
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h00,32'h0,1'b1,32'hA0A00013},        // 20
      '{1'b1,1'b1,1'b0,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h00,32'h0,1'b1,32'hA0A00012},        // 21
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b0,1'b0,8'h00,32'h0,1'b1,32'hA0A00011},        // 22
      '{1'b1,1'b0,1'b1,1'b1,1'b1,4'h0,1'b1,1'b0,1'b1,1'b0,8'h13,32'hFFFFFFFF,1'b1,32'hA0A00011}, // 23 R7
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00013},        // 24
      '{1'b0,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h10,32'h0BAD0BAD,1'b1,32'hA0A00013}, // 25 R12
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00010},        // 26
      '{1'b1,1'b0,1'b1,1'b0,1'b1,4'hF,1'b1,1'b0,1'b1,1'b1,8'h10,32'h0BAD0BAD,1'b0,32'h0},        // 27 R11
      '{1'b1,1'b0,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h10,32'h0,1'b0,32'h0},               // 28
      '{1'b1,1'b1,1'b1,1'b1,1'b1,4'hF,1'b1,1'b0,1'b1,1'b0,8'h00,32'h0,1'b1,32'hA0A00010}         // 29
   };

   function automatic string row_req(int i);
      if (i <= 3)  return "R5";
      if (i <= 5)  return "R6";
      if (i == 6)  return "R8";
      if (i <= 8)  return "R9";
      if (i == 9)  return "R4";
      if (i <= 11) return "R10";
      if (i <= 14) return "R7";
      if (i <= 16) return "R3";
      if (i <= 22) return "R8";
      if (i <= 24) return "R7";
      if (i <= 26) return "R12";
      return "R11";
   endfunction

   task automatic apply(vec_t t);
      p_n = t.p;  c_n = t.c;  adv_n = t.v;  g_n = t.g;  bwe_n = t.b;  bs_n = t.bs;
      sa_n = !t.s; sb = t.s; sc_n = !t.s;
      oe_n = t.o; lin = t.l; slp = t.z; addr = t.a; din = t.d;
   endtask

   task automatic idle();
      p_n = 1'b1; c_n = 1'b1; adv_n = 1'b1; g_n = 1'b1; bwe_n = 1'b1; bs_n = 4'hF;
      sa_n = 1'b0; sb = 1'b1; sc_n = 1'b0; oe_n = 1'b0; lin = 1'b1; slp = 1'b0;
      addr = 8'h00; din = 32'h0;
   endtask

   task automatic check(string req, logic exp_drv, logic [31:0] exp_q);
      n_chk++;
      if (drv !== exp_drv || dout !== exp_q) begin
         n_bad++;
         $display("FAIL %s: drive=%0b dout=%h, expected drive=%0b dout=%h",
                  req, drv, dout, exp_drv, exp_q);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   initial begin
      idle();
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1", 1'b0, 32'h0);            // reset state
      rst_n = 1'b1;
      step();
      check("R1", 1'b0, 32'h0);            // idle continuation with no burst

      for (int i = 0; i < NV; i++) begin
         apply(VT[i]);
         step();
         check(row_req(i), VT[i].ed, VT[i].eq);
      end

      // R2: each select input alone in its inactive state blocks the access
      for (int k = 0; k < 3; k++) begin
         idle();
         c_n  = 1'b0;
         addr = 8'h10;
         if (k == 0) sa_n = 1'b1;
         if (k == 1) sb   = 1'b0;
         if (k == 2) sc_n = 1'b1;
         step();
         idle();
         step();
         check("R2", 1'b0, 32'h0);
      end
      idle();
      c_n  = 1'b0;
      addr = 8'h10;
      step();
      idle();
      step();
      check("R2", 1'b1, 32'hA0A00010);     // fully selected read succeeds

      // R1: reset in the middle of a read stream
      idle();
      c_n  = 1'b0;
      addr = 8'h13;
      step();
      idle();
      rst_n = 1'b0;
      #1;
      check("R1", 1'b0, 32'h0);
      step();
      check("R1", 1'b0, 32'h0);
      rst_n = 1'b1;

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule